// File: doc/BRIEF.md
# Software-Driven Two-Wire Bus Port

This peripheral gives software direct control over the clock and data lines of an I2C-style two-wire bus. Software raises lines by writing ones to a set register and lowers them by writing ones to a clear register, so one line can change without a read-modify-write. Both pads are open-drain: the block only ever pulls a line low or lets it float up through an external pull-up resistor.

A single status read returns the clock level the block is driving together with the data-line level sampled from the pad. All protocol timing, including start and stop conditions, bit shifting and acknowledge handling, is done by software through these registers. Accesses to any other offset in the 4 KB window are flagged with a one-cycle error pulse, and reads there return all ones.

Top module: `twowire_bitbang_reg`

## Requirements
- R1: After reset the line latch is 2'b11, so both pull-low outputs are 0. `rd_data_o` is 0 and `err_o` is 0.
- R2: A write at byte offset 0x000 ORs `wr_data_i[1:0]` into the latch (bit 0 clock, bit 1 data). Bits at positions 2 and up are ignored, and latch bits that are already 1 stay 1.
- R3: A write at byte offset 0x004 clears each latch bit whose matching bit in `wr_data_i[1:0]` is 1 and leaves the other latch bit unchanged. Bits at positions 2 and up are ignored.
- R4: `scl_pull_o` is the inverse of latch bit 0 and `sda_pull_o` is the inverse of latch bit 1. A write changes them in the cycle after the write is accepted.
- R5: A read at byte offset 0x000 sets `rd_data_o` in the following cycle: bit 0 is latch bit 0, bit 1 is the synchronised data line, and bits 31:2 are 0.
- R6: The data-line input passes through two flops before it reaches the status bit. A read shows the level `sda_i` had two clock edges before the read edge.
- R7: A read at any byte offset other than 0x000, including 0x004, returns all ones on `rd_data_o` and pulses `err_o` high in the following cycle.
- R8: A write at any byte offset other than 0x000 and 0x004 leaves the latch unchanged and pulses `err_o` high in the following cycle.
- R9: `err_o` is low in the cycle after an idle cycle or a valid access, so each bad access gives a pulse of exactly one cycle.
- R10: `rd_data_o` holds its value through cycles that carry no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset within the 4 KB window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, registered |
| err_o | output | 1 | One-cycle pulse after an access to an unmapped offset |
| scl_pull_o | output | 1 | Clock pad pull-low enable (1 = drive low) |
| sda_pull_o | output | 1 | Data pad pull-low enable (1 = drive low) |
| sda_i | input | 1 | Data pad input level |

## Verification
The assertions assume that a read and a write never arrive in the same cycle. When they do, a read of 0x000 reports the latch as it was before the write, and the clock-bit property cannot tell which value is intended. The stimulus therefore issues at most one strobe per cycle. It changes `sda_i` only at falling clock edges, so the synchroniser sees clean levels and the two-edge latency can be predicted exactly. Offsets are chosen to include the clear offset as a read target and the top of the window, so every case of the decode is exercised.

// File: rtl/twowire_pkg.sv
package twowire_pkg;
  localparam int unsigned LINE_W = 2;
  localparam int unsigned SCL_BIT = 0;
  localparam int unsigned SDA_BIT = 1;

  typedef struct packed {
    logic set_wr;
    logic clr_wr;
    logic stat_rd;
    logic bad_rd;
    logic bad_wr;
  } acc_t;
endpackage

// File: rtl/twowire_decode.sv
module twowire_decode
  import twowire_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] SET_OFS = '0,
  parameter logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(4)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output acc_t              acc_o
);
  logic hit_set, hit_clr;

  assign hit_set = (addr_i == SET_OFS);
  assign hit_clr = (addr_i == CLR_OFS);

  always_comb begin
    acc_o         = '0;
    acc_o.set_wr  = wr_en_i & hit_set;
    acc_o.clr_wr  = wr_en_i & hit_clr;
    acc_o.bad_wr  = wr_en_i & ~hit_set & ~hit_clr;
    acc_o.stat_rd = rd_en_i & hit_set;
    acc_o.bad_rd  = rd_en_i & ~hit_set;
  end
endmodule

// File: rtl/twowire_out_latch.sv
module twowire_out_latch #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= RST_VAL;
    else if (set_i) q_o <= q_o | mask_i;
    else if (clr_i) q_o <= q_o & ~mask_i;
  end

  a_r2_set_keeps_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (($past(q_o) & ~q_o) == '0));
  a_r3_clear_drops_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(mask_i)) == '0));
  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/twowire_sync.sv
module twowire_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain[i] <= RST_VAL;
          else         chain[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain[i] <= RST_VAL;
          else         chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

  a_r6_first_stage_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (chain[0] == $past(d_i)));
endmodule

// File: rtl/twowire_bitbang_reg.sv
module twowire_bitbang_reg
  import twowire_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = '0,
  parameter logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(4),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o,
  output logic              scl_pull_o,
  output logic              sda_pull_o,
  input  logic              sda_i
);
  localparam int unsigned PAD_W = DATA_W - LINE_W;

  acc_t              acc;
  logic [LINE_W-1:0] lines;
  logic              sda_seen;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:LINE_W];

  twowire_decode #(
    .ADDR_W (ADDR_W),
    .SET_OFS(SET_OFS),
    .CLR_OFS(CLR_OFS)
  ) i_decode (
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i),
    .acc_o  (acc)
  );

  twowire_out_latch #(
    .W      (LINE_W),
    .RST_VAL('1)
  ) i_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (acc.set_wr),
    .clr_i (acc.clr_wr),
    .mask_i(wr_data_i[LINE_W-1:0]),
    .q_o   (lines)
  );

  twowire_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) i_sda_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .q_o   (sda_seen)
  );

  // open-drain: a released line (latch 1) is not pulled
  assign scl_pull_o = ~lines[SCL_BIT];
  assign sda_pull_o = ~lines[SDA_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      err_o <= acc.bad_rd | acc.bad_wr;
      if (acc.stat_rd)     rd_data_o <= {{PAD_W{1'b0}}, sda_seen, lines[SCL_BIT]};
      else if (acc.bad_rd) rd_data_o <= '1;
    end
  end

  a_r7_bad_read_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != SET_OFS) |=> (rd_data_o == '1 && err_o));
  a_r5_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == SET_OFS) |=> (rd_data_o[DATA_W-1:LINE_W] == '0));
  a_r5_status_clock_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == SET_OFS) |=> (rd_data_o[0] == !$past(scl_pull_o)));
  a_r4_clear_pulls_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CLR_OFS && wr_data_i[0]) |=> scl_pull_o);
  a_r8_bad_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != SET_OFS && addr_i != CLR_OFS) |=> (err_o && $stable(scl_pull_o) && $stable(sda_pull_o)));
  a_r9_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && !wr_en_i) |=> !err_o);
  a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/test_twowire_bitbang_reg.sv
`timescale 1ns/1ps
module test_twowire_bitbang_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        err;
  logic        scl_pull, sda_pull;
  logic        sda = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  twowire_bitbang_reg i_twowire_bitbang_reg (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .err_o(err),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .sda_i(sda)
  );

  // behavioural reference
  logic [1:0]  m_lines;
  logic [31:0] m_rd;
  logic        m_err;
  logic        hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lines = 2'b11; m_rd = '0; m_err = 1'b0;
      hist = '{1'b1, 1'b1};
    end else begin
      if (rd_en) m_rd = (addr == 12'h000) ? {30'd0, hist[1], m_lines[0]} : 32'hFFFF_FFFF;
      m_err = (rd_en && addr != 12'h000) ||
              (wr_en && addr != 12'h000 && addr != 12'h004);
      if (wr_en && addr == 12'h000)      m_lines = m_lines | wr_data[1:0];
      else if (wr_en && addr == 12'h004) m_lines = m_lines & ~wr_data[1:0];
      hist.push_front(sda);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R4", "scl_pull", {31'd0, scl_pull}, {31'd0, ~m_lines[0]});
      chk("R4", "sda_pull", {31'd0, sda_pull}, {31'd0, ~m_lines[1]});
      chk(tag, "rd_data", rd_data, m_rd);
      chk(tag, "err", {31'd0, err}, {31'd0, m_err});
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; addr = '0;
  endtask

  task automatic rd(logic [11:0] a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1", "scl_pull", {31'd0, scl_pull}, 32'd0);
    chk("R1", "sda_pull", {31'd0, sda_pull}, 32'd0);
    chk("R1", "rd_data", rd_data, 32'd0);
    chk("R1", "err", {31'd0, err}, 32'd0);
    rst_n = 1'b1;
    live = 1;
    idle(2);
    tag = "R5"; rd(12'h000); idle(1);
    chk("R5", "status after reset", rd_data, 32'h0000_0003);
    tag = "R3"; wr(12'h004, 32'h1); idle(1);
    chk("R3", "clear clock only", {30'd0, sda_pull, scl_pull}, 32'h1);
    wr(12'h004, 32'hFFFF_FFFC); wr(12'h004, 32'h2); idle(1);
    tag = "R5"; rd(12'h000); rd(12'h000);
    tag = "R2"; wr(12'h000, 32'hFFFF_FFFC); wr(12'h000, 32'h2); idle(1);
    chk("R2", "set data only", {30'd0, sda_pull, scl_pull}, 32'h1);
    wr(12'h000, 32'h3); wr(12'h000, 32'h1);
    tag = "R6"; sda = 1'b0; rd(12'h000); rd(12'h000); rd(12'h000);
    chk("R6", "status after sync", rd_data, 32'h0000_0001);
    sda = 1'b1; idle(1); sda = 1'b0; rd(12'h000); sda = 1'b1; rd(12'h000); rd(12'h000);
    tag = "R7"; rd(12'h004); idle(1); rd(12'h008); rd(12'hFFC); rd(12'h001);
    tag = "R10"; rd(12'h000); idle(5);
    tag = "R8"; wr(12'h008, 32'h0); idle(1); wr(12'hFFC, 32'h3); wr(12'h005, 32'h3);
    idle(1);
    chk("R8", "latch after bad writes", {30'd0, sda_pull, scl_pull}, 32'h0);
    tag = "R9"; wr(12'h004, 32'h3); wr(12'h010, 32'h3); wr(12'h000, 32'h1); idle(2);
    tag = "R5"; sda = 1'b0; idle(3); rd(12'h000); idle(1);
    chk("R5", "clock high data low", rd_data, 32'h0000_0001);
    tag = "R10"; idle(4);
    live = 0;
    finish_run();
  end
endmodule